// File: doc/BRIEF.md
# I2C Master Bit Timing Engine

This block turns per-bit requests from an I2C master sequencer into SCL and SDA open-drain drive enables, timed from the core clock. Each request is a start condition, a stop condition, a data bit or an acknowledge slot. The engine produces the SCL waveform from a programmable divider. It places SDA changes a programmable number of core clocks after SCL is pulled low. It issues a one-cycle sample strobe a programmable number of clocks after SCL has risen. Byte framing, addressing, FIFOs and registers belong to the surrounding controller.

SCL is released for the high half of each period. The high-half count starts only once the wire is actually seen high, so a target may stretch the clock. A stretch-timeout limit, counted in whole SCL periods, releases both lines, returns the engine to idle and raises a sticky flag. A limit of zero switches the check off.

Requests are accepted when `req_valid_i` and `req_ready_o` are both high. A data request held valid through the last clock of a high phase is taken on the falling SCL edge, so back-to-back bits keep the exact period.

Top module: `i2c_bit_timer`

## Requirements
- R1: After reset, `scl_oe_o`, `sda_oe_o`, `sample_o` and `timeout_o` are 0 and `req_ready_o` is 1.
- R2: The effective period P is `div_i` with bit 0 cleared, and 2 if that is below 2. Let H = P/2. For a data or ack bit accepted while SCL is held low, SCL stays driven low for H clocks after the accepting edge. When there is no stretching, SCL is then released for H clocks and pulled low again.
- R3: The falling-edge delay FD is taken from `dly_i[31:16]` and clamped to the range 1..H. A request's new SDA drive appears FD clocks after its accepting edge. The drive of a data or ack request is `sda_oe_o = ~req_data_i`, and an unchanged value produces no SDA edge.
- R4: The rising-edge delay RD is taken from `dly_i[15:0]` and clamped to the range 1..H. For data and ack requests, `sample_o` pulses for exactly one cycle RD clocks after SCL release (plus any stretch). `sample_bit_o` holds the SDA wire level at that point.
- R5: While SCL is released but the wire stays low, the high phase is frozen. The sample point and the end of the high phase are both shifted by the number of stalled clocks.
- R6: Kind 2'b00 is a start. From idle, the accepting edge drives SDA low and SCL is pulled low H clocks later. From a held-low SCL, a repeated start releases SDA at FD, releases SCL at H, drives SDA low at 2H and pulls SCL low at 3H.
- R7: Kind 2'b01 is a stop. It drives SDA low at FD and releases SCL at H. It releases SDA at 2H and is idle and ready again from 3H, with both lines released.
- R8: With a nonzero `tmo_i` = T, a stall of T*P clocks sets `timeout_o`, releases both lines and returns to idle. A stall of T*P-1 clocks does not. The flag stays set until the next accepted request.
- R9: With `tmo_i` = 0, no stall length ever sets `timeout_o`.
- R10: Data (2'b10) and ack (2'b11) requests, and stops, accepted while idle are ignored. Both lines stay released, no sample is produced and the engine stays ready.
- R11: A data request held valid across the end of a high phase is accepted on the last high clock. SCL falls exactly H clocks after it rose, so back-to-back bits run at period P.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_i | input | 16 | SCL period in core clocks (bit 0 ignored) |
| dly_i | input | 32 | Falling-edge delay [31:16], rising-edge delay [15:0] |
| tmo_i | input | 16 | Stretch timeout in SCL periods, 0 disables |
| req_valid_i | input | 1 | Request valid |
| req_kind_i | input | 2 | 00 start, 01 stop, 10 data, 11 ack |
| req_data_i | input | 1 | Bit to send, 1 = release SDA |
| req_ready_o | output | 1 | Engine can take a request |
| scl_i | input | 1 | Sensed SCL wire |
| sda_i | input | 1 | Sensed SDA wire |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| sample_o | output | 1 | One-cycle receive sample strobe |
| sample_bit_o | output | 1 | SDA level captured with the strobe |
| timeout_o | output | 1 | Sticky clock-stretch timeout flag |

## Verification
The hardest case to reach is the exact boundary of the stretch timeout. The target has to hold SCL low for precisely T*P-1 and then T*P stalled clocks after the engine lets go, and both runs have to be measured from the release edge. The bench models the open-drain wires with a stretch input. That input is dropped a counted number of clocks after `scl_oe_o` falls, or never dropped for the expiring run. This also places the stretch-shifted sample point. Back-to-back acceptance is reached by keeping a second data request valid through the high phase and checking that the next falling edge lands exactly H clocks after the rise.

// File: rtl/i2c_bt_pkg.sv
package i2c_bt_pkg;
  typedef enum logic [1:0] {
    REQ_START = 2'b00,
    REQ_STOP  = 2'b01,
    REQ_DATA  = 2'b10,
    REQ_ACK   = 2'b11
  } req_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PARK,
    ST_LOW,
    ST_HIGH,
    ST_HOLD_START,
    ST_HOLD_STOP
  } state_e;
endpackage

// File: rtl/i2c_bt_cfg.sv
module i2c_bt_cfg #(
  parameter int DIV_W = 16
) (
  input  logic [DIV_W-1:0]   div_i,
  input  logic [2*DIV_W-1:0] dly_i,
  output logic [DIV_W-1:0]   period_o,
  output logic [DIV_W-1:0]   half_o,
  output logic [DIV_W-1:0]   fdly_o,
  output logic [DIV_W-1:0]   rdly_o
);
  localparam logic [DIV_W-1:0] EVEN_MASK = {{(DIV_W-1){1'b1}}, 1'b0};
  localparam logic [DIV_W-1:0] MIN_PER   = DIV_W'(2);
  localparam logic [DIV_W-1:0] ONE       = DIV_W'(1);

  logic [DIV_W-1:0] even;
  logic [DIV_W-1:0] f_raw, r_raw;

  function automatic logic [DIV_W-1:0] clamp(input logic [DIV_W-1:0] v,
                                             input logic [DIV_W-1:0] hi);
    if (v == '0)     return ONE;
    else if (v > hi) return hi;
    else             return v;
  endfunction

  always_comb begin
    even     = div_i & EVEN_MASK;
    period_o = (even < MIN_PER) ? MIN_PER : even;
    half_o   = period_o >> 1;
    f_raw    = dly_i[2*DIV_W-1:DIV_W];
    r_raw    = dly_i[DIV_W-1:0];
    fdly_o   = clamp(f_raw, half_o);
    rdly_o   = clamp(r_raw, half_o);
  end
endmodule

// File: rtl/i2c_bt_stretch.sv
module i2c_bt_stretch #(
  parameter int DIV_W = 16,
  parameter int TMO_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stall_i,
  input  logic [DIV_W-1:0] period_i,
  input  logic [TMO_W-1:0] limit_i,
  output logic             expire_o
);
  logic [DIV_W-1:0] sub_q;
  logic [TMO_W-1:0] cyc_q;
  logic             wrap;

  assign wrap     = (sub_q == period_i - DIV_W'(1));
  assign expire_o = stall_i && wrap && (limit_i != '0) &&
                    (cyc_q == limit_i - TMO_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sub_q <= '0;
      cyc_q <= '0;
    end else if (!stall_i) begin
      sub_q <= '0;
      cyc_q <= '0;
    end else if (wrap) begin
      sub_q <= '0;
      cyc_q <= cyc_q + TMO_W'(1);
    end else begin
      sub_q <= sub_q + DIV_W'(1);
    end
  end
endmodule

// File: rtl/i2c_bit_timer.sv
module i2c_bit_timer
  import i2c_bt_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int TMO_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [DIV_W-1:0]   div_i,
  input  logic [2*DIV_W-1:0] dly_i,
  input  logic [TMO_W-1:0]   tmo_i,
  input  logic               req_valid_i,
  input  logic [1:0]         req_kind_i,
  input  logic               req_data_i,
  output logic               req_ready_o,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               scl_oe_o,
  output logic               sda_oe_o,
  output logic               sample_o,
  output logic               sample_bit_o,
  output logic               timeout_o
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] period, half, fdly, rdly;
  logic [DIV_W-1:0] cnt_q;
  state_e           state_q;
  logic [1:0]       kind_q;
  logic             pend_q, sda_q, smp_q, smp_bit_q, tmo_q;
  logic             stall, expire, high_last, hold_last, accept;

  i2c_bt_cfg #(.DIV_W(DIV_W)) u_cfg (
    .div_i    (div_i),
    .dly_i    (dly_i),
    .period_o (period),
    .half_o   (half),
    .fdly_o   (fdly),
    .rdly_o   (rdly)
  );

  i2c_bt_stretch #(.DIV_W(DIV_W), .TMO_W(TMO_W)) u_stretch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .stall_i  (stall),
    .period_i (period),
    .limit_i  (tmo_i),
    .expire_o (expire)
  );

  function automatic logic drive_of(input logic [1:0] k, input logic d);
    case (k)
      REQ_START: return 1'b0;
      REQ_STOP:  return 1'b1;
      default:   return ~d;
    endcase
  endfunction

  // high phase frozen until the wire is seen high
  assign stall     = (state_q == ST_HIGH) && (cnt_q == '0) && !scl_i;
  assign high_last = (state_q == ST_HIGH) && !stall && (cnt_q == half - ONE);
  assign hold_last = (state_q == ST_HOLD_START) && (cnt_q == half);

  assign req_ready_o = (state_q == ST_IDLE) || (state_q == ST_PARK) ||
                       (high_last && kind_q[1]) || hold_last;
  assign accept      = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      kind_q    <= REQ_DATA;
      pend_q    <= 1'b0;
      sda_q     <= 1'b0;
      smp_q     <= 1'b0;
      smp_bit_q <= 1'b0;
      tmo_q     <= 1'b0;
    end else begin
      smp_q <= 1'b0;
      if (accept) tmo_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept && req_kind_i == REQ_START) begin
            state_q <= ST_HOLD_START;
            sda_q   <= 1'b1;
            cnt_q   <= ONE;
          end
        end
        ST_PARK: ;
        ST_LOW: begin
          if (cnt_q == fdly) sda_q <= pend_q;
          if (cnt_q == half) begin
            state_q <= ST_HIGH;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + ONE;
          end
        end
        ST_HIGH: begin
          if (stall) begin
            if (expire) begin
              state_q <= ST_IDLE;
              sda_q   <= 1'b0;
              tmo_q   <= 1'b1;
            end
          end else begin
            if (kind_q[1] && cnt_q == rdly - ONE) begin
              smp_q     <= 1'b1;
              smp_bit_q <= sda_i;
            end
            if (cnt_q == half - ONE) begin
              if (kind_q == REQ_START) begin
                state_q <= ST_HOLD_START;
                sda_q   <= 1'b1;
                cnt_q   <= ONE;
              end else if (kind_q == REQ_STOP) begin
                state_q <= ST_HOLD_STOP;
                sda_q   <= 1'b0;
                cnt_q   <= ONE;
              end else begin
                state_q <= ST_PARK;
              end
            end else begin
              cnt_q <= cnt_q + ONE;
            end
          end
        end
        ST_HOLD_START: begin
          if (cnt_q == half) state_q <= ST_PARK;
          else               cnt_q   <= cnt_q + ONE;
        end
        ST_HOLD_STOP: begin
          if (cnt_q == half) state_q <= ST_IDLE;
          else               cnt_q   <= cnt_q + ONE;
        end
        default: state_q <= ST_IDLE;
      endcase
      // any accept outside idle opens a new low phase on this edge
      if (accept && state_q != ST_IDLE) begin
        state_q <= ST_LOW;
        cnt_q   <= ONE;
        kind_q  <= req_kind_i;
        pend_q  <= drive_of(req_kind_i, req_data_i);
      end
    end
  end

  assign scl_oe_o     = (state_q == ST_PARK) || (state_q == ST_LOW);
  assign sda_oe_o     = sda_q;
  assign sample_o     = smp_q;
  assign sample_bit_o = smp_bit_q;
  assign timeout_o    = tmo_q;
endmodule

// File: rtl/i2c_bit_timer_chk.sv
module i2c_bit_timer_chk #(
  parameter int TMO_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [TMO_W-1:0] tmo_i,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic             scl_oe_o,
  input logic             sda_oe_o,
  input logic             sample_o,
  input logic             timeout_o
);
  AST_SAMPLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |=> !sample_o); // R4

  AST_SAMPLE_SCL_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> $past(!scl_oe_o)); // R4

  AST_TMO_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> (!scl_oe_o && !sda_oe_o && req_ready_o)); // R8

  AST_TMO_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timeout_o && !(req_valid_i && req_ready_o)) |=> timeout_o); // R8

  AST_TMO_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> ($past(tmo_i) != '0)); // R9
endmodule

bind i2c_bit_timer i2c_bit_timer_chk #(.TMO_W(TMO_W)) u_chk (.*);

// File: tb/sim_i2c_bit_timer.sv
`timescale 1ns/1ps
module sim_i2c_bit_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] div = 16'd4;
  logic [31:0] dly = 32'd0;
  logic [15:0] tmo = 16'd0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = 2'b10;
  logic        req_data = 1'b1;
  logic        req_ready, scl_oe, sda_oe, sample, sample_bit, timeout;
  logic        stretch = 1'b0, tgt_low = 1'b0;
  logic        scl_line, sda_line;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;
  int ks[4], kd[4];
  int nks, nkd, k_smp, k_tmo;
  logic smp_val;
  int h, fe, re, per;
  logic cur;

  always #2 clk = ~clk;

  assign scl_line = !scl_oe && !stretch;
  assign sda_line = !sda_oe && !tgt_low;

  i2c_bit_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .div_i(div), .dly_i(dly), .tmo_i(tmo),
    .req_valid_i(req_valid), .req_kind_i(req_kind), .req_data_i(req_data),
    .req_ready_o(req_ready), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .sample_o(sample),
    .sample_bit_o(sample_bit), .timeout_o(timeout)
  );

  task automatic chk(input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  function automatic int clampd(input int v, input int hi);
    if (v < 1) return 1;
    if (v > hi) return hi;
    return v;
  endfunction

  task automatic set_cfg(input int d, input int f, input int r);
    @(negedge clk);
    div = 16'(d);
    per = d & ~1;
    if (per < 2) per = 2;
    h  = per / 2;
    fe = clampd(f, h);
    re = clampd(r, h);
    dly = {16'(f), 16'(r)};
  endtask

  task automatic run_req(input logic [1:0] kind, input logic d, input int s_cyc,
                         input int len, input int drop_k);
    logic scl_p, sda_p;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_kind = kind; req_data = d; req_valid = 1'b1;
    stretch = (s_cyc > 0);
    nks = 0; nkd = 0; k_smp = -1; k_tmo = -1;
    scl_p = scl_oe; sda_p = sda_oe;
    @(posedge clk);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      if (k == drop_k) req_valid = 1'b0;
      if (k == 0 && drop_k > 0) req_data = !d;
      if (scl_oe != scl_p) begin
        if (nks < 4) ks[nks] = k;
        nks++;
        scl_p = scl_oe;
      end
      if (sda_oe != sda_p) begin
        if (nkd < 4) kd[nkd] = k;
        nkd++;
        sda_p = sda_oe;
      end
      if (sample && k_smp < 0) begin k_smp = k; smp_val = sample_bit; end
      if (timeout && k_tmo < 0) k_tmo = k;
      if (stretch && nks > 0 && k == ks[0] + s_cyc) stretch = 1'b0;
    end
    stretch = 1'b0;
  endtask

  // data or ack bit from SCL held low
  task automatic do_bit(input logic [1:0] kind, input logic d, input logic tl, input int s);
    tgt_low = tl;
    run_req(kind, d, s, 2*h + s + 4, 0);
    tgt_low = 1'b0;
    chk("R2", "scl edges in bit", nks, 2);
    chk("R2", "low phase length", ks[0], h);
    chk(s > 0 ? "R5" : "R2", "high phase length", ks[1] - ks[0], h + s);
    if ((!d) != cur) begin
      chk("R3", "sda edges", nkd, 1);
      chk("R3", "sda change offset", kd[0], fe);
    end else begin
      chk("R3", "sda edges for unchanged drive", nkd, 0);
    end
    chk(s > 0 ? "R5" : "R4", "sample offset", k_smp, h + s + re);
    chk("R4", "sampled level", int'(smp_val), int'(d && !tl));
    cur = !d;
  endtask

  task automatic do_start_idle();
    run_req(2'b00, 1'b0, 0, h + 3, 0);
    chk("R6", "idle start sda edges", nkd, 1);
    chk("R6", "idle start sda offset", kd[0], 0);
    chk("R6", "idle start scl offset", ks[0], h);
    cur = 1'b1;
  endtask

  task automatic do_restart();
    run_req(2'b00, 1'b0, 0, 3*h + 3, 0);
    chk("R6", "restart scl edges", nks, 2);
    chk("R6", "restart scl release", ks[0], h);
    chk("R6", "restart scl low", ks[1], 3*h);
    if (cur) begin
      chk("R6", "restart sda edges", nkd, 2);
      chk("R6", "restart sda release", kd[0], fe);
      chk("R6", "restart sda low", kd[1], 2*h);
    end else begin
      chk("R6", "restart sda edges", nkd, 1);
      chk("R6", "restart sda low", kd[0], 2*h);
    end
    cur = 1'b1;
  endtask

  task automatic do_stop();
    run_req(2'b01, 1'b0, 0, 3*h + 4, 0);
    chk("R7", "stop scl edges", nks, 1);
    chk("R7", "stop scl release", ks[0], h);
    if (!cur) begin
      chk("R7", "stop sda edges", nkd, 2);
      chk("R7", "stop sda low", kd[0], fe);
      chk("R7", "stop sda release", kd[1], 2*h);
    end else begin
      chk("R7", "stop sda edges", nkd, 1);
      chk("R7", "stop sda release", kd[0], 2*h);
    end
    chk("R7", "idle after stop", int'({req_ready, scl_oe, sda_oe}), 3'b100);
    cur = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual expired expected completion");
    summary();
  end

  initial begin
    int divs[6];
    int fr, rr;
    divs = '{0, 3, 4, 6, 9, 16};
    repeat (3) @(negedge clk);
    chk("R1", "reset outputs", int'({scl_oe, sda_oe, sample, timeout, req_ready}), 5'b00001);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "outputs after reset release", int'({scl_oe, sda_oe, sample, timeout, req_ready}), 5'b00001);
    cur = 1'b0;

    for (int di = 0; di < 6; di++) begin
      for (int pi = 0; pi < 5; pi++) begin
        set_cfg(divs[di], 0, 0);
        case (pi)
          0: begin fr = 0;     rr = h;     end
          1: begin fr = h;     rr = 0;     end
          2: begin fr = h + 3; rr = 65535; end
          3: begin fr = 65535; rr = 1;     end
          default: begin fr = 2; rr = h + 1; end
        endcase
        set_cfg(divs[di], fr, rr);
        do_start_idle();
        do_bit(2'b10, 1'b1, 1'b0, 0);
        do_bit(2'b11, 1'b0, 1'b1, 0);
        do_bit(2'b10, 1'b1, 1'b1, 3);
        do_bit(2'b10, 1'b1, 1'b0, 0);
        // R11 back-to-back: second bit held valid over the high phase
        run_req(2'b10, 1'b1, 0, 4*h + 3, 2*h);
        chk("R11", "chained scl edges", nks, 4);
        chk("R11", "first high start", ks[0], h);
        chk("R11", "falling edge after chained accept", ks[1], 2*h);
        chk("R11", "second high start", ks[2], 3*h);
        chk("R11", "second falling edge", ks[3], 4*h);
        cur = 1'b1;
        do_restart();
        do_bit(2'b10, 1'b0, 1'b0, 0);
        do_bit(2'b10, 1'b1, 1'b0, 1);
        do_stop();
      end
    end

    // stretch timeout with P=4, T=3
    set_cfg(4, 0, 0);
    tmo = 16'd3;
    do_start_idle();
    do_bit(2'b10, 1'b1, 1'b0, 3*per - 1);
    chk("R8", "no timeout one clock short", k_tmo, -1);
    run_req(2'b10, 1'b0, 400, h + 3*per + 4, 0);
    chk("R8", "timeout offset", k_tmo, h + 3*per);
    chk("R8", "lines released and ready after timeout",
        int'({scl_oe, sda_oe, req_ready, timeout}), 4'b0011);
    repeat (5) @(negedge clk);
    chk("R8", "flag held", int'(timeout), 1);

    // R10: requests other than start while idle
    run_req(2'b10, 1'b0, 0, 8, 0);
    chk("R10", "idle data scl/sda edges", nks + nkd, 0);
    chk("R10", "idle data no sample", k_smp, -1);
    chk("R10", "idle data ready/lines", int'({req_ready, scl_oe, sda_oe}), 3'b100);
    chk("R8", "flag cleared by accepted request", int'(timeout), 0);
    run_req(2'b11, 1'b0, 0, 8, 0);
    chk("R10", "idle ack edges", nks + nkd, 0);
    run_req(2'b01, 1'b0, 0, 8, 0);
    chk("R10", "idle stop edges", nks + nkd, 0);
    chk("R10", "idle stop ready/lines", int'({req_ready, scl_oe, sda_oe}), 3'b100);
    cur = 1'b0;

    // R9: timeout disabled
    tmo = 16'd0;
    do_start_idle();
    do_bit(2'b10, 1'b1, 1'b0, 200);
    chk("R9", "no timeout when disabled", k_tmo, -1);
    tmo = 16'd1;
    do_bit(2'b10, 1'b0, 1'b0, per - 1);
    chk("R8", "T=1 boundary no timeout", k_tmo, -1);
    do_stop();

    summary();
  end
endmodule